// File: doc/BRIEF.md
# Synchronous Burst Write Sequencer

This block turns a stream of 16-bit words from a valid/ready host port into write transactions on a synchronous static-memory style bus. The bus side has a bus clock, an active-low chip-select, an active-low address-valid strobe, a 16-bit address bus and a 16-bit data bus. Only the data stream and its clock carry meaning. The address bus stays at zero throughout.

Each transaction has a fixed shape. First comes one address tick, then a programmable number of latency ticks (at least two), then one data tick. When burst mode is on, a second data tick can follow it, so two halfwords move under a single address phase. The bus clock runs only while a transaction is open. Its period is a programmable number of system-clock cycles, and two is the shortest. Strobes and data change only at the falling edge of the bus clock, so they are settled when the bus clock rises.

The divider, latency and burst settings are captured when a word is accepted in idle. Changes made while a transaction is in flight wait for the next one.

Top module: `burst_write_seq`

## Requirements
- R1: After reset: bus_cs_n=1, bus_adv_n=1, bus_clk=0, bus_data=0, bus_addr=0 and in_ready=1.
- R2: While chip-select is low, bus_clk has a period of D system cycles, where D=max(cfg_div,2). In each tick it is low for the first (D+1)/2 cycles and high for the rest. It is held low while idle.
- R3: bus_adv_n is low for exactly the first tick of a transaction, and chip-select is low during that tick. The first tick starts in the cycle after the accepting clock edge.
- R4: Between the address tick and the first data tick there are L latency ticks, where L=max(cfg_lat,2). During those ticks bus_data is zero.
- R5: A single-word transaction holds chip-select low for D*(2+L) cycles. The accepted word is on bus_data during tick 1+L, and bus_data is zero in the other ticks.
- R6: With burst on, a second word offered in the final cycle of the first data tick is consumed. It is driven in tick 2+L, and chip-select stays low for D*(3+L) cycles.
- R7: With burst on and no second word valid at that cycle, the transaction closes after D*(2+L) cycles, as a single-word write.
- R8: in_ready is 1 only while idle, or, with burst on, in the final cycle of the first data tick. A word offered at any other time is ignored and never reaches bus_data.
- R9: cfg_div, cfg_lat and cfg_burst are captured when a word is accepted in idle. Changing them during a transaction does not alter its timing.
- R10: bus_data and bus_adv_n keep the same value across every rising edge of bus_clk.
- R11: Back-to-back transactions leave chip-select high for exactly one system cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 4 | Bus clock ratio in system cycles (values below 2 act as 2) |
| cfg_lat | input | 4 | Latency ticks after the address tick (values below 2 act as 2) |
| cfg_burst | input | 1 | Allow a second halfword per transaction |
| in_valid | input | 1 | Host word valid |
| in_data | input | 16 | Host word |
| in_ready | output | 1 | Word accepted in this cycle when valid |
| bus_clk | output | 1 | Bus clock |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_adv_n | output | 1 | Address-valid strobe, active low |
| bus_addr | output | 16 | Address bus, constant zero |
| bus_data | output | 16 | Data bus |

## Verification
Two events can land in the same system cycle: the end of the first data tick, which is also where the bus clock falls, and the handshake for the burst's second word. The bench raises in_valid with the second word at a random cycle inside the first data tick and holds it there. This tests that in_ready rises only in the tick's last cycle, and that the word shows up on the very next tick without stretching chip-select. The same offer is also made with burst off, where the word must never reach the bus and the transaction must close on time.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_LAT   = 3'd2,
    ST_BEAT1 = 3'd3,
    ST_BEAT2 = 3'd4
  } bsq_state_e;

  // Raise a configuration value to its legal floor.
  function automatic logic [7:0] raise_to_floor(input logic [7:0] raw, input logic [7:0] floor_v);
    return (raw < floor_v) ? floor_v : raw;
  endfunction

  // Number of system cycles the bus clock stays low within one tick.
  function automatic logic [7:0] low_phases(input logic [7:0] ratio);
    return ratio - (ratio >> 1);
  endfunction

endpackage

// File: rtl/bsq_clkgen.sv
module bsq_clkgen #(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [CFG_W-1:0] ratio,
  output logic             bus_clk,
  output logic             tick_end
);
  import bsq_pkg::*;

  logic [CFG_W-1:0] phase;
  logic [7:0]       phase_nx;
  logic [7:0]       low_len;

  assign low_len  = low_phases(8'(ratio));
  assign phase_nx = 8'(phase) + 8'd1;
  assign tick_end = run && (8'(phase) == 8'(ratio) - 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      bus_clk <= 1'b0;
    end else if (start || !run || tick_end) begin
      phase   <= '0;
      bus_clk <= 1'b0;
    end else begin
      phase   <= phase + 1'b1;
      bus_clk <= (phase_nx >= low_len);
    end
  end

  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (8'(phase) < 8'(ratio)));

  p_clk_low_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> !bus_clk);

endmodule

// File: rtl/bsq_ctrl.sv
module bsq_ctrl #(
  parameter int CFG_W   = 4,
  parameter int MIN_DIV = 2,
  parameter int MIN_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_div,
  input  logic [CFG_W-1:0] cfg_lat,
  input  logic             cfg_burst,
  input  logic             in_valid,
  input  logic             tick_end,
  output logic             in_ready,
  output logic             cs_n,
  output logic             adv_n,
  output logic             run,
  output logic             start,
  output logic [CFG_W-1:0] ratio_q,
  output logic             cap_first,
  output logic             drive_first,
  output logic             take_second,
  output logic             finish
);
  import bsq_pkg::*;

  bsq_state_e       state;
  logic [CFG_W-1:0] lat_q;
  logic [CFG_W-1:0] lat_left;
  logic             burst_q;
  logic             second_slot;
  logic             lat_done;

  assign second_slot = (state == ST_BEAT1) && burst_q && tick_end;
  assign in_ready    = (state == ST_IDLE) || second_slot;
  assign cap_first   = (state == ST_IDLE) && in_valid;
  assign take_second = second_slot && in_valid;
  assign lat_done    = (state == ST_LAT) && tick_end && (lat_left == '0);
  assign drive_first = lat_done;
  assign finish      = tick_end && ((state == ST_BEAT2) ||
                                    ((state == ST_BEAT1) && !take_second));
  assign run         = (state != ST_IDLE);
  assign start       = cap_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      adv_n    <= 1'b1;
      ratio_q  <= CFG_W'(MIN_DIV);
      lat_q    <= CFG_W'(MIN_LAT);
      lat_left <= '0;
      burst_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cap_first) begin
          state   <= ST_ADDR;
          cs_n    <= 1'b0;
          adv_n   <= 1'b0;
          ratio_q <= CFG_W'(raise_to_floor(8'(cfg_div), 8'(MIN_DIV)));
          lat_q   <= CFG_W'(raise_to_floor(8'(cfg_lat), 8'(MIN_LAT)));
          burst_q <= cfg_burst;
        end
        ST_ADDR: if (tick_end) begin
          state    <= ST_LAT;
          adv_n    <= 1'b1;
          lat_left <= lat_q - 1'b1;
        end
        ST_LAT: if (tick_end) begin
          if (lat_done) state <= ST_BEAT1;
          else          lat_left <= lat_left - 1'b1;
        end
        ST_BEAT1: if (tick_end) begin
          if (take_second) state <= ST_BEAT2;
          else begin
            state <= ST_IDLE;
            cs_n  <= 1'b1;
          end
        end
        ST_BEAT2: if (tick_end) begin
          state <= ST_IDLE;
          cs_n  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_ready_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_ADDR, ST_LAT, ST_BEAT2}) |-> !in_ready);

  p_adv_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> !cs_n);

  p_adv_on_cs_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !adv_n);

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(ratio_q) && $stable(lat_q) && $stable(burst_q)));

  p_cs_release_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (state == ST_IDLE));

endmodule

// File: rtl/bsq_datapath.sv
module bsq_datapath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cap_first,
  input  logic              drive_first,
  input  logic              take_second,
  input  logic              finish,
  output logic [DATA_W-1:0] bus_data
);

  logic [DATA_W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= '0;
      bus_data <= '0;
    end else begin
      if (cap_first) held <= in_data;
      if (finish)           bus_data <= '0;
      else if (take_second) bus_data <= in_data;
      else if (drive_first) bus_data <= held;
    end
  end

  p_data_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (bus_data == '0));

  p_first_beat_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drive_first |=> (bus_data == $past(held)));

endmodule

// File: rtl/burst_write_seq.sv
module burst_write_seq #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int CFG_W   = 4,
  parameter int MIN_DIV = 2,
  parameter int MIN_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_div,
  input  logic [CFG_W-1:0]  cfg_lat,
  input  logic              cfg_burst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              bus_clk,
  output logic              bus_cs_n,
  output logic              bus_adv_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data
);

  logic             run;
  logic             start;
  logic             tick_end;
  logic [CFG_W-1:0] ratio_q;
  logic             cap_first;
  logic             drive_first;
  logic             take_second;
  logic             finish;

  assign bus_addr = '0;

  bsq_ctrl #(.CFG_W(CFG_W), .MIN_DIV(MIN_DIV), .MIN_LAT(MIN_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_div(cfg_div), .cfg_lat(cfg_lat), .cfg_burst(cfg_burst),
    .in_valid(in_valid), .tick_end(tick_end), .in_ready(in_ready),
    .cs_n(bus_cs_n), .adv_n(bus_adv_n), .run(run), .start(start),
    .ratio_q(ratio_q), .cap_first(cap_first), .drive_first(drive_first),
    .take_second(take_second), .finish(finish)
  );

  bsq_clkgen #(.CFG_W(CFG_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run),
    .ratio(ratio_q), .bus_clk(bus_clk), .tick_end(tick_end)
  );

  bsq_datapath #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .in_data(in_data),
    .cap_first(cap_first), .drive_first(drive_first),
    .take_second(take_second), .finish(finish), .bus_data(bus_data)
  );

  p_data_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_clk) |-> ($stable(bus_data) && $stable(bus_adv_n)));

  p_clk_only_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk |-> !bus_cs_n);

endmodule

// File: tb/test_burst_write_seq.sv
module test_burst_write_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_div = '0;
  logic [3:0]  cfg_lat = '0;
  logic        cfg_burst = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, bus_clk, bus_cs_n, bus_adv_n;
  logic [15:0] bus_addr, bus_data;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  burst_write_seq i_burst_write_seq (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_lat(cfg_lat),
    .cfg_burst(cfg_burst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .bus_clk(bus_clk), .bus_cs_n(bus_cs_n),
    .bus_adv_n(bus_adv_n), .bus_addr(bus_addr), .bus_data(bus_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  function automatic int floor_at(input int raw, input int lo);
    return (raw > lo) ? raw : lo;
  endfunction

  function automatic int low_cycles(input int d);
    return (d + 1) / 2;
  endfunction

  task automatic idle_gap(input int g);
    for (int i = 0; i < g; i++) begin
      @(negedge clk);
      chk(bus_cs_n == 1'b1, "R11", "cs idle", int'(bus_cs_n), 1);
      chk(bus_clk == 1'b0, "R2", "clk idle", int'(bus_clk), 0);
      chk(in_ready == 1'b1, "R8", "ready idle", int'(in_ready), 1);
    end
  endtask

  // Called at a falling edge with the design idle.
  task automatic run_txn(input int div_raw, input int lat_raw, input bit burst,
                         input bit offer2, input logic [15:0] w0,
                         input logic [15:0] w1, input bit scramble);
    int d     = floor_at(div_raw, 2);
    int l     = floor_at(lat_raw, 2);
    int nb    = (burst && offer2) ? 2 : 1;
    int n     = d * (1 + l + nb);
    int kend1 = d * (2 + l) - 1;
    int koff  = d * (1 + l) + int'($urandom_range(0, d - 1));
    int cs_low = 0;
    logic [15:0] prev_data = '0;
    string cs_tag = (nb == 2) ? "R6" : ((burst) ? "R7" : "R5");

    chk(in_ready == 1'b1, "R8", "ready before accept", int'(in_ready), 1);
    cfg_div = 4'(div_raw); cfg_lat = 4'(lat_raw); cfg_burst = burst;
    in_valid = 1'b1; in_data = w0;
    @(posedge clk);
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k == 0) begin
        in_valid = 1'b0; in_data = 16'hdead;
        if (scramble) begin
          cfg_div = 4'($urandom); cfg_lat = 4'($urandom); cfg_burst = ~burst;
        end
      end
      if (offer2 && k == koff) begin in_valid = 1'b1; in_data = w1; end
      if (offer2 && k == kend1 + 1) in_valid = 1'b0;
      if (k < n) begin
        int tk = k / d;
        int ph = k % d;
        logic [15:0] ed = (tk == 1 + l) ? w0 : ((tk == 2 + l) ? w1 : 16'h0);
        bit eclk = (ph >= low_cycles(d));
        chk(bus_cs_n == 1'b0, cs_tag, "cs low", int'(bus_cs_n), 0);
        chk(bus_clk == eclk, "R2", "bus clk", int'(bus_clk), int'(eclk));
        chk(bus_adv_n == (tk != 0), "R3", "adv", int'(bus_adv_n), int'(tk != 0));
        if (tk <= l)
          chk(bus_data == 16'h0, "R4", "latency data", int'(bus_data), 0);
        else if (tk == 1 + l)
          chk(bus_data == ed, "R5", "first beat", int'(bus_data), int'(ed));
        else
          chk(bus_data == ed, "R6", "second beat", int'(bus_data), int'(ed));
        chk(in_ready == (burst && k == kend1), "R8", "ready busy",
            int'(in_ready), int'(burst && k == kend1));
        if (ph == low_cycles(d))
          chk(bus_data == prev_data, "R10", "data at rise", int'(bus_data), int'(prev_data));
      end else begin
        chk(bus_cs_n == 1'b1, "R11", "cs gap", int'(bus_cs_n), 1);
        chk(bus_clk == 1'b0, "R2", "clk after", int'(bus_clk), 0);
        chk(bus_data == 16'h0, "R5", "data after", int'(bus_data), 0);
        chk(bus_adv_n == 1'b1, "R3", "adv after", int'(bus_adv_n), 1);
      end
      if (!bus_cs_n) cs_low++;
      prev_data = bus_data;
    end
    chk(cs_low == n, scramble ? "R9" : cs_tag, "cs low length", cs_low, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog got=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    chk(bus_cs_n == 1'b1, "R1", "reset cs", int'(bus_cs_n), 1);
    chk(bus_adv_n == 1'b1, "R1", "reset adv", int'(bus_adv_n), 1);
    chk(bus_clk == 1'b0, "R1", "reset clk", int'(bus_clk), 0);
    chk(bus_data == 16'h0, "R1", "reset data", int'(bus_data), 0);
    chk(bus_addr == 16'h0, "R1", "reset addr", int'(bus_addr), 0);
    chk(in_ready == 1'b1, "R1", "reset ready", int'(in_ready), 1);
    rst_n = 1'b1;
    idle_gap(3);

    run_txn(2, 2, 1'b0, 1'b0, 16'ha5a5, 16'h0, 1'b0);   // R5 fastest single
    run_txn(3, 2, 1'b1, 1'b1, 16'h1234, 16'h5678, 1'b0); // R6 five ticks
    run_txn(3, 2, 1'b1, 1'b0, 16'h0f0f, 16'h0, 1'b0);   // R7 burst, no partner
    run_txn(2, 3, 1'b0, 1'b1, 16'h7777, 16'hbeef, 1'b0); // R8 offer ignored
    run_txn(0, 0, 1'b0, 1'b0, 16'h0101, 16'h0, 1'b0);   // R2 R4 floors
    run_txn(1, 1, 1'b1, 1'b1, 16'hc3c3, 16'h3c3c, 1'b0);
    run_txn(15, 15, 1'b1, 1'b1, 16'hffff, 16'h8001, 1'b0);
    run_txn(4, 2, 1'b1, 1'b1, 16'h2468, 16'h1357, 1'b1); // R9 settings moved
    idle_gap(2);

    for (int it = 0; it < 150; it++) begin
      run_txn(int'($urandom_range(0, 15)), int'($urandom_range(0, 6)),
              1'($urandom), 1'($urandom), 16'($urandom) | 16'h1,
              16'($urandom) | 16'h1, 1'($urandom));
      if ($urandom_range(0, 3) == 0) idle_gap(int'($urandom_range(1, 4)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule